// File: doc/BRIEF.md
# Pixel-multiplexed LED matrix scanner

This block lights an LED matrix one pixel per time slot. Each pixel has an 8-bit brightness, stored in an external memory that the block reads through a one-cycle-latency read port. A static per-pixel mapping vector tells the block which row line and which column line belong to each pixel. During a slot the pixel's row is held active for the whole slot. Its column is held active from the start of the slot for a time proportional to the brightness.

Slot length is fixed at 255 quanta. The quantum, in clock cycles, is derived from the base clock rate, the wanted refresh rate and the pixel count. Two pulse inputs turn blanking on and off. While blanked, every row and column line rests at its inactive level. The active level of each line is chosen separately through a configuration bit.

Top module: `led_scan_matrix`

## Requirements
- R1: After reset the block is blanked: each row line and each column line equals its active-low configuration bit (its inactive level).
- R2: At no time is more than one row line, or more than one column line, at its active level.
- R3: While scanning, pixels are shown in increasing index order, and pixel NPIX-1 is followed by pixel 0.
- R4: Byte i of `pix_map` (bits 8i+7..8i) describes pixel i. Bits 8i+7..8i+4 hold the row index and bits 8i+3..8i hold the column index. The row named there is active for the whole slot of pixel i.
- R5: Each slot lasts PERIOD = 255 x QUANT clock cycles, where QUANT = BASE_HZ / (REFRESH_HZ x NPIX x 255) rounded down.
- R6: In the slot of a pixel with brightness b, its column is active for the first b x QUANT cycles of the slot and inactive for the rest. For b = 0 the column never becomes active.
- R7: A line whose active-low bit is 1 is driven low when active and high when inactive. A line whose bit is 0 is driven the other way round.
- R8: A `blank_set` pulse while scanning stops the scan. From the next cycle on, every line is inactive.
- R9: A `blank_clr` pulse while blanked starts the scan with the slot timer at zero. One full dark slot follows, with all lines inactive, and then pixel 0 is shown.
- R10: A `blank_set` pulse while blanked, or a `blank_clr` pulse while scanning, has no effect on any output.
- R11: `mem_addr` carries the index of the pixel that comes next. During the dark lead-in slot this is 0. The brightness returned one cycle after an address is taken in the last cycle of the current slot.
- R12: When `blank_set` and `blank_clr` are both high in the same cycle, `blank_set` takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| blank_set | input | 1 | Pulse: stop scanning and blank all lines |
| blank_clr | input | 1 | Pulse: leave blanking and start scanning |
| pix_map | input | NPIX*8 | Per-pixel byte: row index in the upper nibble, column index in the lower nibble |
| row_act_low | input | NROWS | Per-row active-low configuration |
| col_act_low | input | NCOLS | Per-column active-low configuration |
| mem_addr | output | IDX_W | Brightness memory read address (next pixel) |
| mem_rdata | input | 8 | Brightness memory read data, one cycle after the address |
| row_drv | output | NROWS | Row drive lines |
| col_drv | output | NCOLS | Column drive lines |

## Verification
The line outputs follow registered state through logic only, so the effect of an input sampled at one rising edge shows at the falling edge after it. The bench samples every falling edge and counts samples from the edge that took a `blank_clr` pulse. Samples 0 to PERIOD-1 must be dark. Sample t at or beyond PERIOD must show pixel ((t-PERIOD)/PERIOD) mod NPIX, and its column must be active while (t-PERIOD) mod PERIOD is below b x QUANT. A `blank_set` must give dark lines at the very next falling-edge sample. Redundant pulses are applied inside this same per-cycle timeline, so any disturbance they cause shows up as a mismatch against the same expected pattern.

// File: rtl/led_scan_pkg.sv
// Package: shared constants and types for the LED matrix scanner.
// Assumes brightness values are 8 bits and map nibbles are 4 bits.
package led_scan_pkg;
    localparam int BRIGHT_STEPS = 255;
    localparam int NIB_W        = 4;
    typedef logic [7:0] bright_t;
    typedef struct packed {
        logic [NIB_W-1:0] row;
        logic [NIB_W-1:0] col;
    } map_entry_t;
endpackage

// File: rtl/scan_slot_timer.sv
// Module: counts clock cycles inside one scan slot.
// Assumes: start restarts the count at zero; the count advances only while run is high.
module scan_slot_timer #(
    parameter int PERIOD = 510,
    parameter int CNT_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    output logic [CNT_W-1:0] cnt,
    output logic             slot_end
);
    assign slot_end = run && (cnt == CNT_W'(PERIOD - 1));

    // Purpose: advance the in-slot counter and wrap it at the end of a slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (start)    cnt <= '0;
        else if (slot_end) cnt <= '0;
        else if (run)      cnt <= cnt + CNT_W'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(PERIOD)); // R5
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> cnt == '0); // R5
endmodule

// File: rtl/scan_sequencer.sv
// Module: holds the blanking state, the current pixel index and its brightness.
// Assumes: blank_set wins over blank_clr; the memory returns data one cycle after an address.
module scan_sequencer
    import led_scan_pkg::*;
#(
    parameter int NPIX  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_set,
    input  logic             blank_clr,
    input  logic             slot_end,
    input  bright_t          mem_rdata,
    output logic             run,
    output logic             lead,
    output logic             start,
    output logic [IDX_W-1:0] idx,
    output bright_t          bright,
    output logic [IDX_W-1:0] mem_addr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

    logic             stop;
    logic [IDX_W-1:0] nxt;

    assign start    = blank_clr && !blank_set && !run;
    assign stop     = blank_set && run;
    assign nxt      = (idx == LAST) ? '0 : idx + IDX_W'(1);
    assign mem_addr = nxt;

    // Purpose: apply blanking changes and step to the next pixel at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            lead   <= 1'b0;
            idx    <= LAST;
            bright <= '0;
        end else if (stop) begin
            run    <= 1'b0;
            lead   <= 1'b0;
        end else if (start) begin
            run    <= 1'b1;
            lead   <= 1'b1;
            idx    <= LAST;
            bright <= '0;
        end else if (slot_end) begin
            idx    <= nxt;
            bright <= mem_rdata;
            lead   <= 1'b0;
        end
    end

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        run && slot_end && !blank_set && idx == LAST |=> idx == '0); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && slot_end && !blank_set && idx != LAST |=> idx == $past(idx) + IDX_W'(1)); // R3
    AST_BLANK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        blank_set |=> !run); // R8
    AST_START_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && blank_clr && !blank_set |=> run && lead && idx == LAST); // R9
    AST_KEEP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run && !blank_set |=> run); // R10
endmodule

// File: rtl/scan_line_driver.sv
// Module: decodes the current pixel into row and column drive levels.
// Assumes: pix_map is static while scanning; map indices beyond the line count light nothing.
module scan_line_driver
    import led_scan_pkg::*;
#(
    parameter int NPIX  = 8,
    parameter int NROWS = 4,
    parameter int NCOLS = 4,
    parameter int QUANT = 2,
    parameter int IDX_W = 3,
    parameter int CNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              lead,
    input  logic [IDX_W-1:0]  idx,
    input  bright_t           bright,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [NPIX*8-1:0] pix_map,
    input  logic [NROWS-1:0]  row_act_low,
    input  logic [NCOLS-1:0]  col_act_low,
    output logic [NROWS-1:0]  row_drv,
    output logic [NCOLS-1:0]  col_drv
);
    map_entry_t       cur;
    logic [CNT_W-1:0] pulse;
    logic             lit;
    logic             pulse_on;
    logic [NROWS-1:0] row_on;
    logic [NCOLS-1:0] col_on;

    assign cur      = map_entry_t'(pix_map[idx*8 +: 8]);
    assign pulse    = CNT_W'(bright) * CNT_W'(QUANT);
    assign lit      = run && !lead;
    assign pulse_on = lit && (cnt < pulse);

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        assign row_on[r]  = lit && (cur.row == NIB_W'(r));
        assign row_drv[r] = row_on[r] ^ row_act_low[r];
    end

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        assign col_on[c]  = pulse_on && (cur.col == NIB_W'(c));
        assign col_drv[c] = col_on[c] ^ col_act_low[c];
    end

    AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_on)); // R2
    AST_ONE_COL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_on)); // R2
    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (col_on != '0) && (cur.row < NIB_W'(NROWS)) |-> row_on != '0); // R6
    AST_DARK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        lead |-> row_on == '0 && col_on == '0); // R9
endmodule

// File: rtl/led_scan_matrix.sv
// Module: top of the pixel-multiplexed LED matrix scanner.
// Assumes: NPIX >= 2, NROWS and NCOLS <= 16, PERIOD fits in 16 bits,
// brightness memory has one cycle of read latency.
module led_scan_matrix
    import led_scan_pkg::*;
#(
    parameter int NPIX       = 8,
    parameter int NROWS      = 4,
    parameter int NCOLS      = 4,
    parameter int BASE_HZ    = 4080000,
    parameter int REFRESH_HZ = 1000,
    localparam int IDX_W     = $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_set,
    input  logic              blank_clr,
    input  logic [NPIX*8-1:0] pix_map,
    input  logic [NROWS-1:0]  row_act_low,
    input  logic [NCOLS-1:0]  col_act_low,
    output logic [IDX_W-1:0]  mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [NROWS-1:0]  row_drv,
    output logic [NCOLS-1:0]  col_drv
);
    localparam int QUANT  = BASE_HZ / (REFRESH_HZ * NPIX * BRIGHT_STEPS);
    localparam int PERIOD = BRIGHT_STEPS * QUANT;
    localparam int CNT_W  = $clog2(PERIOD + 1);

    logic             run, lead, start, slot_end;
    logic [IDX_W-1:0] idx;
    bright_t          bright;
    logic [CNT_W-1:0] cnt;

    scan_slot_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start),
        .cnt(cnt), .slot_end(slot_end)
    );

    scan_sequencer #(.NPIX(NPIX), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .blank_set(blank_set), .blank_clr(blank_clr),
        .slot_end(slot_end), .mem_rdata(mem_rdata), .run(run), .lead(lead),
        .start(start), .idx(idx), .bright(bright), .mem_addr(mem_addr)
    );

    scan_line_driver #(
        .NPIX(NPIX), .NROWS(NROWS), .NCOLS(NCOLS), .QUANT(QUANT),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .run(run), .lead(lead), .idx(idx),
        .bright(bright), .cnt(cnt), .pix_map(pix_map),
        .row_act_low(row_act_low), .col_act_low(col_act_low),
        .row_drv(row_drv), .col_drv(col_drv)
    );

    AST_BLANK_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        blank_set && blank_clr |=> (row_drv == row_act_low) && (col_drv == col_act_low)); // R12
endmodule

// File: tb/led_scan_matrix_bench.sv
`timescale 1ns/1ps
module led_scan_matrix_bench;
    localparam int NPIX = 8, NROWS = 4, NCOLS = 4;
    localparam int BASE_HZ = 4080000, REFRESH_HZ = 1000;
    localparam int QUANT  = BASE_HZ / (REFRESH_HZ * NPIX * 255);
    localparam int PERIOD = 255 * QUANT;
    localparam int IDX_W  = $clog2(NPIX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blank_set = 1'b0, blank_clr = 1'b0;
    logic [NPIX*8-1:0] pix_map = '0;
    logic [NROWS-1:0] row_act_low = '0;
    logic [NCOLS-1:0] col_act_low = '0;
    logic [IDX_W-1:0] mem_addr;
    logic [7:0] mem_q;
    logic [NROWS-1:0] row_drv;
    logic [NCOLS-1:0] col_drv;
    logic [7:0] fb [NPIX];
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    led_scan_matrix #(.NPIX(NPIX), .NROWS(NROWS), .NCOLS(NCOLS),
        .BASE_HZ(BASE_HZ), .REFRESH_HZ(REFRESH_HZ)) u_led_scan_matrix (
        .clk(clk), .rst_n(rst_n), .blank_set(blank_set), .blank_clr(blank_clr),
        .pix_map(pix_map), .row_act_low(row_act_low), .col_act_low(col_act_low),
        .mem_addr(mem_addr), .mem_rdata(mem_q), .row_drv(row_drv), .col_drv(col_drv));

    // brightness memory model with one cycle of read latency (R11)
    always @(posedge clk) mem_q <= fb[mem_addr];

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected active-high row vector at sample t after unblank (R4, R5, R9)
    function automatic int exp_row(int t);
        int p;
        if (t < PERIOD) return 0;
        p = ((t - PERIOD) / PERIOD) % NPIX;
        return 1 << pix_map[p*8+4 +: 4];
    endfunction

    // expected active-high column vector (R6)
    function automatic int exp_col(int t);
        int p, off;
        if (t < PERIOD) return 0;
        p = ((t - PERIOD) / PERIOD) % NPIX;
        off = (t - PERIOD) % PERIOD;
        return (off < fb[p] * QUANT) ? (1 << pix_map[p*8 +: 4]) : 0;
    endfunction

    function automatic int exp_addr(int t);
        if (t < PERIOD) return 0;
        return (((t - PERIOD) / PERIOD) + 1) % NPIX;
    endfunction

    task automatic check_dark(string tag);
        check({tag, " rows inactive"}, int'(row_drv), int'(row_act_low));
        check({tag, " cols inactive"}, int'(col_drv), int'(col_act_low));
    endtask

    // scan for n samples from unblank; one redundant blank_clr at t_red (R10)
    task automatic run_scan(int n, int t_red);
        blank_clr = 1'b1;
        @(negedge clk);
        blank_clr = 1'b0;
        for (int t = 0; t < n; t++) begin
            int ra, ca;
            ra = int'(row_drv ^ row_act_low);
            ca = int'(col_drv ^ col_act_low);
            check("R3 R4 R5 R7 R9 R10 row", ra, exp_row(t));
            check("R6 R7 R11 col", ca, exp_col(t));
            check("R11 mem_addr", int'(mem_addr), exp_addr(t));
            check("R2 single line", ($countones(ra) <= 1 && $countones(ca) <= 1) ? 1 : 0, 1);
            blank_clr = (t == t_red);
            @(negedge clk);
        end
        blank_clr = 1'b0;
    endtask

    task automatic blank_and_check();
        blank_set = 1'b1;
        @(negedge clk);
        blank_set = 1'b0;
        check_dark("R8 after blank_set");
        blank_set = 1'b1;      // redundant while blanked (R10)
        @(negedge clk);
        blank_set = 1'b0;
        for (int k = 0; k < PERIOD + 5; k++) @(negedge clk);
        check_dark("R8 R10 stays blanked");
    endtask

    task automatic load_random(bit directed);
        for (int i = 0; i < NPIX; i++) begin
            if (directed) begin
                pix_map[i*8 +: 8] = {4'(i % NROWS), 4'((i / NROWS + i) % NCOLS)};
                fb[i] = (i == 0) ? 8'd0 : (i == 1) ? 8'd255 : (i == 2) ? 8'd1 : 8'(i * 30);
            end else begin
                pix_map[i*8 +: 8] = {4'($urandom_range(NROWS - 1)), 4'($urandom_range(NCOLS - 1))};
                fb[i] = 8'($urandom_range(255));
            end
        end
        if (!directed) begin
            fb[NPIX-1] = 8'd255;
            fb[1] = 8'd0;
            row_act_low = NROWS'($urandom);
            col_act_low = NCOLS'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NPIX; i++) fb[i] = 8'd0;
        row_act_low = 4'b1010;
        col_act_low = 4'b0110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_dark("R1 reset");
        // both pulses together while blanked: set wins (R12)
        blank_set = 1'b1;
        blank_clr = 1'b1;
        @(negedge clk);
        blank_set = 1'b0;
        blank_clr = 1'b0;
        check_dark("R12 set wins");
        for (int k = 0; k < PERIOD + 3; k++) @(negedge clk);
        check_dark("R12 still blanked");
        // directed pattern, positive polarity
        row_act_low = '0;
        col_act_low = '0;
        load_random(1'b1);
        run_scan(PERIOD * (NPIX + 1) + 37, PERIOD * 3 + 11);
        blank_and_check();
        // random scenarios, blanked at arbitrary points in a slot
        for (int s = 0; s < 3; s++) begin
            load_random(1'b0);
            run_scan(PERIOD * (NPIX + 2) + int'($urandom_range(PERIOD - 1)),
                     int'($urandom_range(PERIOD * NPIX)));
            blank_and_check();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule